// File: doc/BRIEF.md
# Dual-Loop Lock Detector

This block decides whether a two-loop frequency synthesizer is locked. It watches the combined up-or-down pulse from the phase-frequency detector of each loop, the main loop and the auxiliary loop. It runs on a fast sampling clock, so it can measure how long each pulse stays high. A pulse that stays high for a full reference period or longer means that loop has too much phase error. The limit is a count input, `lock_window`, and `ref_tick` marks the end of each reference period. Each loop gets one good or bad verdict per reference period. A small filter holds back changes to the loop's flag until several verdicts in a row agree.

A shared hardware pin is XORed with a software bit for each loop, and the result decides whether that loop is powered. The single `lock` output takes only powered loops into account. When a loop comes out of power-down, the block gives a one-cycle pulse that the loop's dividers use to restart in phase.

Top module: `dual_lock_detect`

## Requirements
- R1: A loop is powered when `pon` XOR its software bit is 1. With `pon`=0, a software bit of 1 powers the loop. With `pon`=1, a software bit of 0 powers the loop.
- R2: A loop's verdict for a reference period is bad if its pulse has a run of consecutive high samples that reaches `lock_window` cycles. Otherwise the verdict is good. The sample in the `ref_tick` cycle counts toward the verdict of the period that tick closes. A high run that spans a tick keeps counting.
- R3: A loop's lock flag takes a new value only after FILT_N verdicts in a row (default 3) disagree with its current value. Any verdict that agrees with the flag restarts that count.
- R4: `lock` is 1 only when every powered loop has its flag set. It is registered and follows the flags one clock later.
- R5: A powered-down loop has no effect on `lock`, whatever its detector pulse does.
- R6: `lock` is 0 when both loops are powered down.
- R7: Power-down clears a loop's flag and its filter count. After power-up, the flag needs FILT_N good verdicts before it sets.
- R8: When a loop goes from powered down to powered, its divider-sync output is high for exactly one cycle, the cycle after the change. It is low at all other times.
- R9: During and right after reset, `lock` and both sync outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe at the end of each reference period |
| lock_window | input | CNT_W | One reference period, counted in sampling-clock cycles |
| pon | input | 1 | Hardware power-control pin, shared by both loops |
| main_sw_pd | input | 1 | Software power bit of the main loop |
| aux_sw_pd | input | 1 | Software power bit of the auxiliary loop |
| main_pfd | input | 1 | Main detector up-or-down pulse |
| aux_pfd | input | 1 | Auxiliary detector up-or-down pulse |
| lock | output | 1 | Combined lock indication |
| main_div_sync | output | 1 | Main-loop divider resynchronisation pulse |
| aux_div_sync | output | 1 | Auxiliary-loop divider resynchronisation pulse |

## Verification
The lock flags, the filter counts and the run-length counters are all internal state. They reach the ports only through `lock`, so a wrong count appears as `lock` changing one reference period too early or too late. The bench places its checks at exact period counts to catch that: after two bad periods and after three, and after two good periods following power-up and after three. A run counter that fails to clear or to saturate shows up as a wrong verdict right at the boundary widths, where a run is either one cycle short of `lock_window` or equal to it. A power-state register that is wrong appears within one clock, as a missing, doubled or stray sync pulse.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;
    localparam int LOOP_MAIN = 0;
    localparam int LOOP_AUX  = 1;
    localparam int NUM_LOOPS = 2;

    // powered loops must all be locked; nothing powered means no lock
    function automatic logic combine_lock(input logic [NUM_LOOPS-1:0] up,
                                          input logic [NUM_LOOPS-1:0] flag);
        logic ok;
        ok = |up;
        for (int i = 0; i < NUM_LOOPS; i++) begin
            if (up[i] && !flag[i]) ok = 1'b0;
        end
        return ok;
    endfunction
endpackage

// File: rtl/lock_pwr_gate.sv
module lock_pwr_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pon,
    input  logic sw_pd,
    output logic up,
    output logic div_sync
);
    typedef struct packed {
        logic up;
        logic sync;
    } pwr_st_t;

    pwr_st_t st_d, st_q;
    logic    up_now;

    always_comb begin
        up_now     = pon ^ sw_pd;
        st_d.up    = up_now;
        st_d.sync  = up_now & ~st_q.up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up       = up_now;
    assign div_sync = st_q.sync;
endmodule

// File: rtl/lock_loop_meas.sv
module lock_loop_meas #(
    parameter int CNT_W  = 16,
    parameter int FILT_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             ref_tick,
    input  logic             pfd_pulse,
    input  logic [CNT_W-1:0] window,
    output logic             locked
);
    localparam int FW = $clog2(FILT_N + 1);
    localparam logic [FW-1:0] FILT_LAST = FW'(FILT_N - 1);

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic             err;
        logic [FW-1:0]    filt;
        logic             lock;
    } meas_st_t;

    meas_st_t st_d, st_q;
    logic     bad_now;
    logic     verdict;
    logic [CNT_W:0] run_inc;

    always_comb begin
        st_d    = st_q;
        run_inc = {1'b0, st_q.run} + 1'b1;
        bad_now = pfd_pulse && (run_inc >= {1'b0, window});
        verdict = !(st_q.err || bad_now);

        if (pfd_pulse) begin
            if (st_q.run != '1) st_d.run = st_q.run + 1'b1;
        end else begin
            st_d.run = '0;
        end

        if (ref_tick) begin
            st_d.err = 1'b0;
            if (verdict == st_q.lock) begin
                st_d.filt = '0;
            end else if (st_q.filt == FILT_LAST) begin
                st_d.lock = verdict;
                st_d.filt = '0;
            end else begin
                st_d.filt = st_q.filt + 1'b1;
            end
        end else begin
            st_d.err = st_q.err | bad_now;
        end

        if (!active) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.lock;
endmodule

// File: rtl/dual_lock_detect.sv
module dual_lock_detect #(
    parameter int CNT_W  = 16,
    parameter int FILT_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic [CNT_W-1:0] lock_window,
    input  logic             pon,
    input  logic             main_sw_pd,
    input  logic             aux_sw_pd,
    input  logic             main_pfd,
    input  logic             aux_pfd,
    output logic             lock,
    output logic             main_div_sync,
    output logic             aux_div_sync
);
    import lock_det_pkg::*;

    typedef struct packed {
        logic lock;
    } top_st_t;

    logic [NUM_LOOPS-1:0] sw_vec, pfd_vec, up_vec, sync_vec, flag_vec;
    logic main_up, aux_up, main_flag, aux_flag;
    top_st_t st_d, st_q;

    assign sw_vec[LOOP_MAIN]  = main_sw_pd;
    assign sw_vec[LOOP_AUX]   = aux_sw_pd;
    assign pfd_vec[LOOP_MAIN] = main_pfd;
    assign pfd_vec[LOOP_AUX]  = aux_pfd;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        lock_pwr_gate u_pwr (
            .clk      (clk),
            .rst_n    (rst_n),
            .pon      (pon),
            .sw_pd    (sw_vec[g]),
            .up       (up_vec[g]),
            .div_sync (sync_vec[g])
        );
        lock_loop_meas #(.CNT_W(CNT_W), .FILT_N(FILT_N)) u_meas (
            .clk       (clk),
            .rst_n     (rst_n),
            .active    (up_vec[g]),
            .ref_tick  (ref_tick),
            .pfd_pulse (pfd_vec[g]),
            .window    (lock_window),
            .locked    (flag_vec[g])
        );
    end

    assign main_up   = up_vec[LOOP_MAIN];
    assign aux_up    = up_vec[LOOP_AUX];
    assign main_flag = flag_vec[LOOP_MAIN];
    assign aux_flag  = flag_vec[LOOP_AUX];

    always_comb begin
        st_d.lock = combine_lock(up_vec, flag_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock          = st_q.lock;
    assign main_div_sync = sync_vec[LOOP_MAIN];
    assign aux_div_sync  = sync_vec[LOOP_AUX];
endmodule

// File: rtl/dual_lock_chk.sv
module dual_lock_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_tick,
    input logic mu,
    input logic au,
    input logic mflag,
    input logic aflag,
    input logic msync,
    input logic async_p,
    input logic lock
);
    // R6
    both_down_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mu && !au) |=> !lock);

    // R4
    lock_needs_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> ($past(mflag) || !$past(mu)));

    // R4
    lock_needs_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> ($past(aflag) || !$past(au)));

    // R8
    main_sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msync |=> !msync);

    // R8
    aux_sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        async_p |=> !async_p);

    // R8
    main_sync_after_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msync |-> $past(mu));

    // R3
    main_flag_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mflag) |-> ($past(ref_tick) || !$past(mu)));

    // R7
    aux_flag_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !au |=> !aflag);
endmodule

bind dual_lock_detect dual_lock_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .mu       (main_up),
    .au       (aux_up),
    .mflag    (main_flag),
    .aflag    (aux_flag),
    .msync    (main_div_sync),
    .async_p  (aux_div_sync),
    .lock     (lock)
);

// File: tb/sim_dual_lock_detect.sv
module sim_dual_lock_detect;
    localparam int CNT_W = 16;
    localparam int PER   = 10;

    typedef struct packed {
        logic       pon;
        logic       pdm;
        logic       pda;
        logic [3:0] wm;
        logic [3:0] wa;
        logic       exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b1, 4'd2,  4'd3,  1'b1},  // R1 R4 both good
        '{1'b0, 1'b1, 1'b1, 4'd10, 4'd2,  1'b0},  // R2 main run = window
        '{1'b0, 1'b1, 1'b1, 4'd2,  4'd10, 1'b0},  // R2 aux run = window
        '{1'b0, 1'b1, 1'b1, 4'd9,  4'd0,  1'b1},  // R2 run one short
        '{1'b0, 1'b0, 1'b1, 4'd10, 4'd2,  1'b1},  // R5 main down, bad
        '{1'b0, 1'b1, 1'b0, 4'd2,  4'd10, 1'b1},  // R5 aux down, bad
        '{1'b0, 1'b0, 1'b0, 4'd2,  4'd2,  1'b0},  // R6 both down
        '{1'b1, 1'b0, 1'b0, 4'd3,  4'd1,  1'b1},  // R1 pon=1 pd=0 up
        '{1'b1, 1'b1, 1'b1, 4'd2,  4'd2,  1'b0},  // R1 R6 pon=1 pd=1
        '{1'b1, 1'b0, 1'b1, 4'd1,  4'd10, 1'b1}   // R1 R5 aux down
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic [CNT_W-1:0] lock_window = CNT_W'(PER);
    logic pon = 1'b0, main_sw_pd = 1'b0, aux_sw_pd = 1'b0;
    logic main_pfd = 1'b0, aux_pfd = 1'b0;
    logic lock, main_div_sync, aux_div_sync;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    dual_lock_detect #(.CNT_W(CNT_W), .FILT_N(3)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .lock_window(lock_window),
        .pon(pon), .main_sw_pd(main_sw_pd), .aux_sw_pd(aux_sw_pd),
        .main_pfd(main_pfd), .aux_pfd(aux_pfd), .lock(lock),
        .main_div_sync(main_div_sync), .aux_div_sync(aux_div_sync)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%b exp=%b", req, act, exp);
        end
    endtask

    // pulse high during the last w cycles of each period; tick on the last cycle
    task automatic run_periods(input int n, input int wm, input int wa);
        for (int p = 0; p < n; p++) begin
            for (int c = 0; c < PER; c++) begin
                @(negedge clk);
                main_pfd = (c >= PER - wm);
                aux_pfd  = (c >= PER - wa);
                ref_tick = (c == PER - 1);
            end
        end
        @(negedge clk);
        main_pfd = 1'b0;
        aux_pfd  = 1'b0;
        ref_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 lock in reset", lock, 1'b0);
        check("R9 main sync in reset", main_div_sync, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 lock after reset", lock, 1'b0);
        check("R9 aux sync after reset", aux_div_sync, 1'b0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            pon        = VECS[v].pon;
            main_sw_pd = VECS[v].pdm;
            aux_sw_pd  = VECS[v].pda;
            run_periods(4, int'(VECS[v].wm), int'(VECS[v].wa));
            check($sformatf("R4 vector %0d", v), lock, VECS[v].exp);
        end

        // both loops powered, locked
        @(negedge clk);
        pon = 1'b0; main_sw_pd = 1'b1; aux_sw_pd = 1'b1;
        run_periods(4, 2, 2);
        check("R4 relock", lock, 1'b1);

        // R3 filter
        run_periods(2, 10, 2);
        check("R3 two bad periods hold lock", lock, 1'b1);
        run_periods(1, 2, 2);
        check("R3 good period keeps lock", lock, 1'b1);
        run_periods(2, 10, 2);
        check("R3 count restarted", lock, 1'b1);
        run_periods(1, 10, 2);
        check("R3 third bad period drops lock", lock, 1'b0);
        run_periods(4, 2, 2);
        check("R3 relock after good", lock, 1'b1);

        // R5 and R7 power-down clear
        @(negedge clk);
        main_sw_pd = 1'b0;
        run_periods(1, 10, 2);
        check("R5 main down ignored", lock, 1'b1);
        main_sw_pd = 1'b1;
        run_periods(2, 2, 2);
        check("R7 flag cleared, two good not enough", lock, 1'b0);
        run_periods(1, 2, 2);
        check("R7 third good sets flag", lock, 1'b1);

        // R8 sync pulse
        @(negedge clk);
        aux_sw_pd = 1'b0;
        @(negedge clk);
        check("R8 no sync on power-down", aux_div_sync, 1'b0);
        @(negedge clk);
        aux_sw_pd = 1'b1;
        @(negedge clk);
        check("R8 aux sync pulse", aux_div_sync, 1'b1);
        check("R8 main sync quiet", main_div_sync, 1'b0);
        @(negedge clk);
        check("R8 aux sync one cycle", aux_div_sync, 1'b0);

        // R2 with a shorter programmed window
        @(negedge clk);
        lock_window = CNT_W'(5);
        run_periods(4, 2, 2);
        check("R2 window 5 good", lock, 1'b1);
        run_periods(4, 5, 2);
        check("R2 window 5 run of 5", lock, 1'b0);
        run_periods(4, 4, 2);
        check("R2 window 5 run of 4", lock, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule